// File: doc/BRIEF.md
# On/Off Count PWM Generator

A single-channel pulse-width modulator whose waveform is built from two separate lengths: an ON phase of `on_count + 1` prescaled ticks followed by an OFF phase of `off_count + 1` prescaled ticks. The full period is the sum of the two. The duty cycle is the ON length divided by that sum. Both counts at zero give a 50 % square wave two ticks long.

The block runs on one system clock. Its timebase is one of two single-cycle tick strobes, a fast one and a slow one, supplied by the surrounding logic. A configuration word picks the strobe and divides it by `p + 1` through a 4-bit prescaler. The same word also sets which output level means ON and starts or stops the generator. Stopping the generator clears the prescaler and phase counters but keeps the programmed counts.

Software programs the block through a small register port. It is a 16-bit write/read bus addressed by a 2-bit word index, and read data is returned one cycle after the index is presented.

Top module: `onoff_pwm`

## Requirements
- R1: Word index 0 holds the ON count, index 1 the OFF count and index 2 the configuration; index 3 reads as zero. `rd_data` shows the register selected by `reg_idx` one clock after the index is presented.
- R2: The ON and OFF counts keep all 16 written bits. The configuration keeps bits 6:0 only, and bits 15:7 read as zero.
- R3: While running with the prescaler at 0 and the fast tick present every cycle, the ON level lasts `on_count + 1` cycles and the OFF level lasts `off_count + 1` cycles.
- R4: Configuration bits 6:3 hold a value p. The phase counter advances once every p+1 selected ticks, which multiplies both phase lengths by p+1.
- R5: Configuration bit 1 picks the timebase: 0 uses `tick_fast` and 1 uses `tick_slow`. The unselected strobe has no effect.
- R6: Configuration bit 2 sets polarity: 0 drives `pwm_out` high during the ON phase, and 1 drives it low during the ON phase.
- R7: While configuration bit 0 (run) is 0, `pwm_out` sits at the OFF level, which equals bit 2. Clearing run leaves the ON and OFF count registers unchanged.
- R8: Setting run from 0 starts a full ON phase in the cycle after the write, with the prescaler and phase counter at zero.
- R9: A count written while running does not change the phase in progress. It takes effect the next time that phase begins.
- R10: After reset all registers read zero and `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Fast timebase strobe, one cycle wide |
| tick_slow | input | 1 | Slow timebase strobe, one cycle wide |
| wr_en | input | 1 | Write strobe for the register selected by `reg_idx` |
| reg_idx | input | 2 | Register word index |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data for `reg_idx` |
| pwm_out | output | 1 | Modulated output |

## Verification
The main function is driven from a table of count, prescaler, timebase and polarity settings. Each entry measures a whole ON run and a whole OFF run in cycles.

- Entries with equal counts, with the longer phase ON, and with the longer phase OFF show that the two lengths are set separately.
- Nonzero prescaler values separate the divide-by-p+1 path from a straight tick.
- Slow-timebase entries run with the slow strobe at a period unlike the fast one, so a wrong selection shows up as a wrong length.
- Inverted-polarity entries show that the ON length follows the phase and not the high level.

Directed cases then rewrite a count inside a running phase. They also stop and restart the generator and check what readback returns through the masked register fields.

// File: rtl/onoff_pwm.sv
module onoff_pwm #(
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic          wr_en,
  input  logic [1:0]    reg_idx,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic          pwm_out
);
  localparam int GW = 3 + PW;

  logic [CW-1:0] on_r, off_r, lim, ccnt;
  logic [GW-1:0] cfg_r;
  logic [PW-1:0] pcnt;
  logic          ph_on;

  wire          run   = cfg_r[0];
  wire          tsel  = cfg_r[1];
  wire          pol   = cfg_r[2];
  wire [PW-1:0] pre   = cfg_r[GW-1:3];
  wire          tick  = tsel ? tick_slow : tick_fast;
  wire          pwrap = (pcnt >= pre);
  wire          adv   = run & tick & pwrap;
  wire          edge_ = adv & (ccnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_r  <= '0;
      off_r <= '0;
      cfg_r <= '0;
    end else if (wr_en) begin
      case (reg_idx)
        2'd0:    on_r  <= wr_data;
        2'd1:    off_r <= wr_data;
        2'd2:    cfg_r <= wr_data[GW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else begin
      case (reg_idx)
        2'd0:    rd_data <= on_r;
        2'd1:    rd_data <= off_r;
        2'd2:    rd_data <= CW'(cfg_r);
        default: rd_data <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (!run)  pcnt <= '0;
    else if (tick)  pcnt <= pwrap ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_on <= 1'b1;
      ccnt  <= '0;
      lim   <= '0;
    end else if (!run) begin
      ph_on <= 1'b1;
      ccnt  <= '0;
      lim   <= on_r;
    end else if (edge_) begin
      ph_on <= ~ph_on;
      ccnt  <= '0;
      lim   <= ph_on ? off_r : on_r;
    end else if (adv) begin
      ccnt  <= ccnt + 1'b1;
    end
  end

  assign pwm_out = pol ^ (run & ph_on);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_idx) == 2'd2) |-> (rd_data[CW-1:GW] == '0));
  assert_phase_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (ph_on != $past(ph_on))) |-> $past(adv && ccnt == lim));
  assert_adv_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && ccnt != $past(ccnt) && ccnt != '0) |-> $past(tick));
  assert_stopped_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ccnt == '0 && pcnt == '0 && ph_on));
  assert_start_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (ph_on && ccnt == '0 && pcnt == '0));
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ccnt <= lim));
endmodule

// File: tb/onoff_pwm_bench.sv
module onoff_pwm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_fast = 1'b1;
  logic tick_slow = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] reg_idx = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic pwm_out;
  int nchk = 0, nerr = 0, scnt = 0;

  always #5 clk = ~clk;

  // slow strobe: one cycle in five
  always @(negedge clk) begin
    scnt <= (scnt == 4) ? 0 : scnt + 1;
    tick_slow <= (scnt == 4);
  end

  onoff_pwm u_onoff_pwm (.clk, .rst_n, .tick_fast, .tick_slow, .wr_en,
                         .reg_idx, .wr_data, .rd_data, .pwm_out);

  // fields: on[21:14] off[13:6] pre[5:2] tsel[1] pol[0]
  localparam logic [21:0] VEC [8] = '{
    {8'd0, 8'd0, 4'd0,  1'b0, 1'b0},
    {8'd3, 8'd1, 4'd0,  1'b0, 1'b0},
    {8'd1, 8'd4, 4'd2,  1'b0, 1'b0},
    {8'd2, 8'd0, 4'd0,  1'b1, 1'b0},
    {8'd0, 8'd2, 4'd1,  1'b1, 1'b1},
    {8'd5, 8'd5, 4'd15, 1'b0, 1'b0},
    {8'd4, 8'd0, 4'd0,  1'b0, 1'b1},
    {8'd0, 8'd7, 4'd3,  1'b0, 1'b0}
  };

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] i, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] i, output int d);
    @(negedge clk);
    reg_idx = i;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic run_len(logic lvl, output int n);
    int g = 0;
    n = 0;
    while (pwm_out !== lvl && g < 5000) begin g++; @(negedge clk); end
    while (pwm_out === lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int d, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out", int'(pwm_out), 0);
    for (int i = 0; i < 3; i++) begin
      rd(i[1:0], d);
      chk("R10 reg", d, 0);
    end

    for (int v = 0; v < 8; v++) begin
      int on  = VEC[v][21:14];
      int off = VEC[v][13:6];
      int pre = VEC[v][5:2];
      int ts  = VEC[v][1];
      int pl  = VEC[v][0];
      int mul = (pre + 1) * (ts ? 5 : 1);
      int mon, moff;
      wr(2, 16'h0);
      wr(0, 16'(on));
      wr(1, 16'(off));
      wr(2, 16'({pre[3:0], pl[0], ts[0], 1'b1}));
      run_len(~pl[0], n);
      run_len(pl[0], moff);
      run_len(~pl[0], mon);
      chk("R3 R4 R5 R6 on length", mon, (on + 1) * mul);
      chk("R3 R4 R5 R6 off length", moff, (off + 1) * mul);
    end

    // R1 R2 readback and masking
    wr(2, 16'h0);
    wr(0, 16'h1234);
    wr(1, 16'h5678);
    wr(2, 16'hFFF0);
    rd(0, d); chk("R1 on reg", d, 16'h1234);
    rd(1, d); chk("R1 off reg", d, 16'h5678);
    rd(2, d); chk("R2 cfg mask", d, 16'h0070);
    rd(3, d); chk("R1 slot 3 zero", d, 0);
    @(negedge clk);
    chk("R7 stopped level pol0", int'(pwm_out), 0);
    wr(2, 16'h0004);
    chk("R7 stopped level pol1", int'(pwm_out), 1);

    // R8 start in ON, R9 mid-phase rewrite
    wr(2, 16'h0);
    wr(0, 16'd3);
    wr(1, 16'd3);
    wr(2, 16'h0001);
    chk("R8 starts on", int'(pwm_out), 1);
    n = 1;
    wr_en = 1'b1; reg_idx = 2'd0; wr_data = 16'd0;
    @(negedge clk);
    wr_en = 1'b0;
    while (pwm_out === 1'b1 && n < 100) begin n++; @(negedge clk); end
    chk("R8 R9 first on full", n, 4);
    run_len(1'b0, n);
    chk("R9 off length", n, 4);
    run_len(1'b1, n);
    chk("R9 new on length", n, 1);

    // R7 stop mid-run
    wr(2, 16'h0);
    chk("R7 stop level", int'(pwm_out), 0);
    rd(1, d); chk("R7 off kept", d, 3);
    rd(0, d); chk("R7 on kept", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule